// File: doc/BRIEF.md
# Memory-Sequenced Two-Register Compute Loop

This block is a small compute engine. It has two 8-bit working registers, called A and B, and an arithmetic/logic unit between them. A sequencer drives the loads and the operation. The sequencer is a state register whose next value and control signals are read from a control store: one word per state, addressed by the present state. No decoding logic is reduced or minimised. The program that comes out of reset runs three steps in a loop:

- A takes A plus B.
- B takes A minus B.
- A takes A OR B.

The loop then returns to its first step.

The control store can be rewritten while a halt input freezes the engine. This lets the same datapath run a different sequence of operations. Reset sets both registers to values given as parameters and reloads the three-step program. The state and both registers are visible at the ports.

Top module: `seqdp_top`

## Requirements
- R1: While reset is asserted, and until the first active step after it, the state is 0, A equals `A_INIT`, B equals `B_INIT`, and the control store holds the three-step program.
- R2: Each control word is 7 bits, laid out as follows. Bits 6:5 hold the next state. Bits 4:2 hold the operation code. Bit 1 is the load enable for A. Bit 0 is the load enable for B. On every cycle without halt, the state register takes the next-state field of the word addressed by the present state.
- R3: In state 0, the default word is 0x2E (next 1, code 011 add, load A). A becomes (A + B) mod 256.
- R4: In state 1, the default word is 0x49 (next 2, code 010 subtract, load B). B becomes (A − B) mod 256.
- R5: In state 2, the default word is 0x16 (next 0, code 101 OR, load A). A becomes A | B.
- R6: A register whose load enable is low keeps its value across the clock edge.
- R7: State 3 has the default word 0x00: next state 0 and no loads.
- R8: While `halt` is high, the state, A and B all keep their values.
- R9: A write to the control store (`cw_we` high) takes effect only while `halt` is high. With `halt` low, the write is ignored and the running sequence is unchanged.
- R10: A word written at address `cw_addr` with `cw_data` replaces that state's control word from the next cycle on. This changes the operation sequence. Operation codes other than 011, 010 and 101 pass A through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| halt | input | 1 | Freezes the sequencer and the registers, and enables control-store writes |
| cw_we | input | 1 | Control-store write request |
| cw_addr | input | 2 | State whose word is written |
| cw_data | input | 7 | Control word to write |
| acc_a | output | 8 | Register A |
| acc_b | output | 8 | Register B |
| state | output | 2 | Present sequencer state |

## Verification
The default loop runs for many passes starting from nonzero register values. Wrap-around of the sum and the difference therefore shows whether each step uses the right operation and loads the right register. A write made without halt, followed by more free running, separates gated writes from writes that leak into the store. A reprogrammed two-state loop in which B is loaded by OR and A by add shows that the store, and not fixed logic, steers the datapath. A program that routes through state 3 shows the empty word returning to state 0 with both registers held. A second reset taken mid-run shows that both the registers and the program are restored.

// File: rtl/seqdp_pkg.sv
package seqdp_pkg;
  localparam int ST_W  = 2;
  localparam int N_ST  = 1 << ST_W;
  localparam int FN_W  = 3;

  localparam logic [FN_W-1:0] OP_SUB = 3'b010;
  localparam logic [FN_W-1:0] OP_ADD = 3'b011;
  localparam logic [FN_W-1:0] OP_OR  = 3'b101;

  typedef struct packed {
    logic [ST_W-1:0] nxt;
    logic [FN_W-1:0] op;
    logic            ld_a;
    logic            ld_b;
  } ctrl_word_t;

  localparam int CW_W = $bits(ctrl_word_t);

  // Program loaded at reset: add->A, sub->B, or->A, then back to state 0.
  function automatic ctrl_word_t boot_word(input int idx);
    ctrl_word_t w;
    case (idx)
      0:       w = '{nxt: 2'd1, op: OP_ADD, ld_a: 1'b1, ld_b: 1'b0};
      1:       w = '{nxt: 2'd2, op: OP_SUB, ld_a: 1'b0, ld_b: 1'b1};
      2:       w = '{nxt: 2'd0, op: OP_OR,  ld_a: 1'b1, ld_b: 1'b0};
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/seqdp_alu.sv
module seqdp_alu
  import seqdp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  input  logic [FN_W-1:0] op,
  output logic [DW-1:0]   res
);
  always_comb begin
    case (op)
      OP_ADD:  res = opa + opb;
      OP_SUB:  res = opa - opb;
      OP_OR:   res = opa | opb;
      default: res = opa;
    endcase
  end
endmodule

// File: rtl/seqdp_loadreg.sv
module seqdp_loadreg #(
  parameter int          DW      = 8,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_nxt;
  end

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> q == $past(q)); // R6
endmodule

// File: rtl/seqdp_ctrl_mem.sv
module seqdp_ctrl_mem
  import seqdp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            wr_req,
  input  logic [ST_W-1:0] wr_addr,
  input  ctrl_word_t      wr_word,
  input  logic [ST_W-1:0] rd_addr,
  output ctrl_word_t      rd_word
);
  ctrl_word_t [N_ST-1:0] words;
  logic                  wr_ok;

  assign wr_ok   = hold & wr_req;
  assign rd_word = words[rd_addr];

  for (genvar g = 0; g < N_ST; g++) begin : g_word
    logic wr_hit;
    assign wr_hit = wr_ok && (wr_addr == ST_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      words[g] <= boot_word(g);
      else if (wr_hit) words[g] <= wr_word;
    end
  end

  AST_NO_WRITE_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> words == $past(words)); // R9
endmodule

// File: rtl/seqdp_top.sv
module seqdp_top
  import seqdp_pkg::*;
#(
  parameter int          DW     = 8,
  parameter logic [DW-1:0] A_INIT = '0,
  parameter logic [DW-1:0] B_INIT = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt,
  input  logic            cw_we,
  input  logic [ST_W-1:0] cw_addr,
  input  logic [CW_W-1:0] cw_data,
  output logic [DW-1:0]   acc_a,
  output logic [DW-1:0]   acc_b,
  output logic [ST_W-1:0] state
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  ctrl_word_t      cw;
  logic [ST_W-1:0] st_q, st_nxt;
  logic [DW-1:0]   alu_y;
  logic            en_a, en_b;

  seqdp_ctrl_mem u_store (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .hold    (halt),
    .wr_req  (cw_we),
    .wr_addr (cw_addr),
    .wr_word (ctrl_word_t'(cw_data)),
    .rd_addr (st_q),
    .rd_word (cw)
  );

  always_comb begin
    st_nxt = st_q;
    if (!halt) st_nxt = cw.nxt;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) st_q <= '0;
    else          st_q <= st_nxt;
  end

  assign en_a = cw.ld_a & ~halt;
  assign en_b = cw.ld_b & ~halt;

  seqdp_alu #(.DW(DW)) u_alu (
    .opa (acc_a),
    .opb (acc_b),
    .op  (cw.op),
    .res (alu_y)
  );

  seqdp_loadreg #(.DW(DW), .RST_VAL(A_INIT)) u_reg_a (
    .clk (clk), .rst_n (rst_s_n), .load (en_a), .d (alu_y), .q (acc_a)
  );

  seqdp_loadreg #(.DW(DW), .RST_VAL(B_INIT)) u_reg_b (
    .clk (clk), .rst_n (rst_s_n), .load (en_b), .d (alu_y), .q (acc_b)
  );

  assign state = st_q;

  AST_STATE_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_s_n)
    !halt |=> st_q == $past(cw.nxt)); // R2
  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_s_n)
    halt |=> (st_q == $past(st_q)) && (acc_a == $past(acc_a)) && (acc_b == $past(acc_b))); // R8
endmodule

// File: tb/tb_seqdp_top.sv
module tb_seqdp_top;
  localparam logic [7:0] AI = 8'h05;
  localparam logic [7:0] BI = 8'h03;

  logic       clk = 1'b0;
  logic       rst_n, halt, cw_we;
  logic [1:0] cw_addr;
  logic [6:0] cw_data;
  logic [7:0] acc_a, acc_b;
  logic [1:0] state;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  seqdp_top #(.DW(8), .A_INIT(AI), .B_INIT(BI)) dut (
    .clk(clk), .rst_n(rst_n), .halt(halt), .cw_we(cw_we),
    .cw_addr(cw_addr), .cw_data(cw_data),
    .acc_a(acc_a), .acc_b(acc_b), .state(state)
  );

  typedef struct {
    logic [7:0] a;
    logic [7:0] b;
    logic [1:0] s;
    string      tag;
  } exp_t;
  exp_t q[$];

  // Model built from the requirement text.
  logic [6:0] m_mem [4];
  logic [7:0] m_a, m_b;
  logic [1:0] m_s;

  function automatic logic [6:0] cw(input logic [1:0] nx, input logic [2:0] op,
                                    input logic la, input logic lb);
    return {nx, op, la, lb};
  endfunction

  task automatic model_reset();
    m_mem[0] = 7'h2E; m_mem[1] = 7'h49; m_mem[2] = 7'h16; m_mem[3] = 7'h00;
    m_a = AI; m_b = BI; m_s = 2'd0;
  endtask

  task automatic step(input logic h, input logic we, input logic [1:0] ad,
                      input logic [6:0] dt, input string tag);
    exp_t e;
    logic [6:0] w;
    logic [7:0] y;
    string t;
    @(negedge clk);
    halt = h; cw_we = we; cw_addr = ad; cw_data = dt;
    t = tag;
    if (h) begin
      if (we) m_mem[ad] = dt;
    end else begin
      w = m_mem[m_s];
      if (m_s == 2'd3) t = "R7";
      case (w[4:2])
        3'b011:  y = m_a + m_b;
        3'b010:  y = m_a - m_b;
        3'b101:  y = m_a | m_b;
        default: y = m_a;
      endcase
      if (w[1]) m_a = y;
      if (w[0]) m_b = y;
      m_s = w[6:5];
    end
    e.a = m_a; e.b = m_b; e.s = m_s; e.tag = t;
    q.push_back(e);
  endtask

  // Monitor: compares one expected item after each clock edge.
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (acc_a !== e.a || acc_b !== e.b || state !== e.s) begin
        n_bad++;
        $display("FAIL %s: got a=%h b=%h s=%0d, expected a=%h b=%h s=%0d",
                 e.tag, acc_a, acc_b, state, e.a, e.b, e.s);
      end
    end
  end

  task automatic check_reset(input string tag);
    n_vec++;
    if (acc_a !== AI || acc_b !== BI || state !== 2'd0) begin
      n_bad++;
      $display("FAIL %s: got a=%h b=%h s=%0d, expected a=%h b=%h s=0",
               tag, acc_a, acc_b, state, AI, BI);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; halt = 1'b1; cw_we = 1'b0; cw_addr = '0; cw_data = '0;
    repeat (3) @(negedge clk);
    check_reset("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
    check_reset("R1");
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; halt = 1'b1; cw_we = 1'b0; cw_addr = '0; cw_data = '0;
    model_reset();
    do_reset();

    // Default loop over many passes: R3 add, R4 subtract, R5 or.
    for (int i = 0; i < 30; i++) begin
      case (m_s)
        2'd0:    step(1'b0, 1'b0, 2'd0, 7'h0, "R3");
        2'd1:    step(1'b0, 1'b0, 2'd0, 7'h0, "R4");
        default: step(1'b0, 1'b0, 2'd0, 7'h0, "R5");
      endcase
    end

    // R8: halt freezes everything.
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 2'd0, 7'h0, "R8");

    // R9: writes without halt are ignored; the loop continues unchanged.
    step(1'b0, 1'b1, 2'd0, 7'h00, "R9");
    step(1'b0, 1'b1, 2'd1, 7'h00, "R9");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 2'd0, 7'h0, "R9");

    // R10: new two-state program: B <= A|B, then A <= A+B.
    step(1'b1, 1'b1, 2'd0, cw(2'd1, 3'b101, 1'b0, 1'b1), "R10");
    step(1'b1, 1'b1, 2'd1, cw(2'd0, 3'b011, 1'b1, 1'b0), "R10");
    step(1'b1, 1'b1, 2'd2, cw(2'd0, 3'b000, 1'b1, 1'b0), "R10");
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 2'd0, 7'h0, "R10");

    // R7 / R6: route through state 3, which loads nothing.
    step(1'b1, 1'b1, 2'd0, 7'h2E, "R7");
    step(1'b1, 1'b1, 2'd1, 7'h49, "R7");
    step(1'b1, 1'b1, 2'd2, cw(2'd3, 3'b101, 1'b1, 1'b0), "R7");
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 2'd0, 7'h0, "R6");

    // R1: reset mid-run restores registers and the default program.
    repeat (2) @(negedge clk);
    do_reset();
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 2'd0, 7'h0, "R1");
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule